// File: doc/BRIEF.md
# Outbound Buffer Release Decision Unit

This unit sits beside the local-pointer walker of a DMA instruction processor. Each cycle it may accept one local pointer of the instruction being executed. With each pointer it receives the instruction's header controls: the transfer type, the header override bit and the header release bit. It also receives the pointer's own invert bit, backup count, pool number and byte address, the pointer's position in the instruction, and the size of the source-pointer area.

For every pointer it decides whether the buffer behind that pointer goes back to a hardware free pool. A buffer is only ever returned during a device-bound (outbound) transfer. When the header override bit is set, the header release bit alone decides. Otherwise the header release bit is combined with the pointer's invert bit.

A returned buffer is described by its start address and its pool. The start address is found by rounding the data pointer down to a 128-byte block and stepping back by the backup count of whole blocks. Requests leave through a registered valid/ready stream in pointer order. If stepping back would pass address zero, the unit raises a one-cycle error pulse instead of a request.

Top module: `bf_release_unit`

## Requirements
- R1: Transfer type is encoded 0 = outbound, 1 = inbound, 2 = internal, 3 = external. A pointer accepted with any type other than 0 never produces a release request or an error pulse.
- R2: For an outbound pointer in the source area with `hdr_ovr` = 1, a release happens exactly when `hdr_rel` = 1, whatever `ptr_inv` is.
- R3: For an outbound pointer in the source area with `hdr_ovr` = 0, a release happens exactly when `hdr_rel` XOR `ptr_inv` is 1.
- R4: `rel_addr` equals ((`ptr_addr` >> 7) − `ptr_back`) << 7, so its low 7 bits are always zero.
- R5: `rel_pool` equals the accepted pointer's `ptr_pool`, one of eight pools.
- R6: Only pointers with `ptr_idx` < `src_count` are in the source area. Any other pointer produces neither a request nor an error.
- R7: If a pointer that would be released has `ptr_back` greater than `ptr_addr` >> 7, `err_underflow` is high for exactly the cycle after acceptance and no request is issued for it. Equality is legal and yields address 0.
- R8: `ptr_back` and `ptr_pool` have no effect when the pointer is not released. In particular, a large backup count on such a pointer raises no error.
- R9: A pointer is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its request is valid from that edge on. While `rel_valid` is high and `rel_ready` is low, the request holds stable and `in_ready` is low.
- R10: Requests leave in the order their pointers were accepted.
- R11: After reset `rel_valid` and `err_underflow` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pointer is offered |
| in_ready | output | 1 | Unit can take the pointer this cycle |
| xfer_type | input | 2 | Transfer type of the instruction |
| hdr_ovr | input | 1 | Header override: ignore per-pointer invert |
| hdr_rel | input | 1 | Header release bit |
| ptr_idx | input | 4 | Position of this pointer in the instruction |
| src_count | input | 4 | Number of pointers in the source area |
| ptr_inv | input | 1 | Per-pointer invert bit |
| ptr_back | input | 4 | Backup count in 128-byte blocks |
| ptr_pool | input | 3 | Destination free pool |
| ptr_addr | input | 36 | Byte address of the data |
| rel_valid | output | 1 | Release request valid |
| rel_ready | input | 1 | Pool side takes the request |
| rel_addr | output | 36 | Start address of the buffer to release |
| rel_pool | output | 3 | Pool receiving the buffer |
| err_underflow | output | 1 | Backup count passed address zero |

## Verification
Every result of an accepted pointer appears one register later. The request or the error pulse is due right after the acceptance edge, and `in_ready` reacts combinationally to `rel_ready` within the same cycle. The bench drives inputs just after the rising edge. It advances a behavioural model on each rising edge from the same inputs. On every falling edge it compares `in_ready`, `rel_valid`, `err_underflow` and, when valid, the address and pool, so each result is judged in the cycle it is due. Random back-pressure on `rel_ready` tests the hold and ordering rules.

// File: rtl/bf_pkg.sv
package bf_pkg;
    // Transfer type code; value 0 is the only one that can release buffers.
    typedef enum logic [1:0] {
        XFER_OUT    = 2'd0,
        XFER_IN     = 2'd1,
        XFER_LOCAL  = 2'd2,
        XFER_REMOTE = 2'd3
    } xfer_e;

    localparam int unsigned BLK_SHIFT = 7;  // 128-byte blocks
endpackage

// File: rtl/bf_decide.sv
module bf_decide #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned BACK_W = 4,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [1:0]        xfer_type,
    input  logic              hdr_ovr,
    input  logic              hdr_rel,
    input  logic [IDX_W-1:0]  ptr_idx,
    input  logic [IDX_W-1:0]  src_count,
    input  logic              ptr_inv,
    input  logic [BACK_W-1:0] ptr_back,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic              want_rel,
    output logic              underflow,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int unsigned SH    = bf_pkg::BLK_SHIFT;
    localparam int unsigned BLK_W = ADDR_W - SH;

    logic             in_src;
    logic             rel_bit;
    logic [BLK_W:0]   blk_ext;
    logic [BLK_W:0]   back_ext;
    logic [BLK_W:0]   diff;

    always_comb begin
        in_src   = ptr_idx < src_count;
        rel_bit  = hdr_ovr ? hdr_rel : (hdr_rel ^ ptr_inv);
        want_rel = (xfer_type == bf_pkg::XFER_OUT) && in_src && rel_bit;

        blk_ext  = {1'b0, ptr_addr[ADDR_W-1:SH]};
        back_ext = {{(BLK_W + 1 - BACK_W){1'b0}}, ptr_back};
        diff     = blk_ext - back_ext;
        underflow  = diff[BLK_W];
        start_addr = {diff[BLK_W-1:0], {SH{1'b0}}};
    end
endmodule

// File: rtl/bf_out_stage.sv
module bf_out_stage #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned POOL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              issue,
    input  logic              flag_err,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [POOL_W-1:0] new_pool,
    input  logic              rel_ready,
    output logic              stall,
    output logic              rel_valid,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [POOL_W-1:0] rel_pool,
    output logic              err_pulse
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [POOL_W-1:0] pool;
        logic              err;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.valid && rel_ready) begin
            st_d.valid = 1'b0;
        end
        if (take) begin
            st_d.valid = issue;
            st_d.err   = flag_err;
            if (issue) begin
                st_d.addr = new_addr;
                st_d.pool = new_pool;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall     = st_q.valid && !rel_ready;
    assign rel_valid = st_q.valid;
    assign rel_addr  = st_q.addr;
    assign rel_pool  = st_q.pool;
    assign err_pulse = st_q.err;
endmodule

// File: rtl/bf_release_unit.sv
module bf_release_unit #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned BACK_W = 4,
    parameter int unsigned POOL_W = 3,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        xfer_type,
    input  logic              hdr_ovr,
    input  logic              hdr_rel,
    input  logic [IDX_W-1:0]  ptr_idx,
    input  logic [IDX_W-1:0]  src_count,
    input  logic              ptr_inv,
    input  logic [BACK_W-1:0] ptr_back,
    input  logic [POOL_W-1:0] ptr_pool,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic              rel_valid,
    input  logic              rel_ready,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [POOL_W-1:0] rel_pool,
    output logic              err_underflow
);
    logic              want_rel;
    logic              underflow;
    logic [ADDR_W-1:0] start_addr;
    logic              stall;
    logic              take;

    bf_decide #(.ADDR_W(ADDR_W), .BACK_W(BACK_W), .IDX_W(IDX_W)) u_decide (
        .xfer_type (xfer_type),
        .hdr_ovr   (hdr_ovr),
        .hdr_rel   (hdr_rel),
        .ptr_idx   (ptr_idx),
        .src_count (src_count),
        .ptr_inv   (ptr_inv),
        .ptr_back  (ptr_back),
        .ptr_addr  (ptr_addr),
        .want_rel  (want_rel),
        .underflow (underflow),
        .start_addr(start_addr)
    );

    assign in_ready = !stall;
    assign take     = in_valid && !stall;

    bf_out_stage #(.ADDR_W(ADDR_W), .POOL_W(POOL_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .issue    (want_rel && !underflow),
        .flag_err (want_rel && underflow),
        .new_addr (start_addr),
        .new_pool (ptr_pool),
        .rel_ready(rel_ready),
        .stall    (stall),
        .rel_valid(rel_valid),
        .rel_addr (rel_addr),
        .rel_pool (rel_pool),
        .err_pulse(err_underflow)
    );
endmodule

// File: rtl/bf_release_chk.sv
module bf_release_chk #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned BACK_W = 4,
    parameter int unsigned POOL_W = 3,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        xfer_type,
    input logic              hdr_ovr,
    input logic              hdr_rel,
    input logic [IDX_W-1:0]  ptr_idx,
    input logic [IDX_W-1:0]  src_count,
    input logic              ptr_inv,
    input logic [BACK_W-1:0] ptr_back,
    input logic [POOL_W-1:0] ptr_pool,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              rel_valid,
    input logic              rel_ready,
    input logic [ADDR_W-1:0] rel_addr,
    input logic [POOL_W-1:0] rel_pool,
    input logic              err_underflow
);
    p_non_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && xfer_type != 2'd0) |=> (!rel_valid && !err_underflow));

    p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ptr_idx >= src_count) |=> (!rel_valid && !err_underflow));

    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_addr[6:0] == 7'd0));

    p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> !rel_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_addr) && $stable(rel_pool)));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |-> !in_ready);
endmodule

bind bf_release_unit bf_release_chk #(
    .ADDR_W(ADDR_W), .BACK_W(BACK_W), .POOL_W(POOL_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/bf_release_unit_bench.sv
module bf_release_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  xfer_type = 2'd0;
    logic        hdr_ovr = 1'b0;
    logic        hdr_rel = 1'b0;
    logic [3:0]  ptr_idx = 4'd0;
    logic [3:0]  src_count = 4'd0;
    logic        ptr_inv = 1'b0;
    logic [3:0]  ptr_back = 4'd0;
    logic [2:0]  ptr_pool = 3'd0;
    logic [35:0] ptr_addr = 36'd0;
    logic        rel_valid;
    logic        rel_ready = 1'b1;
    logic [35:0] rel_addr;
    logic [2:0]  rel_pool;
    logic        err_underflow;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    bp_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R11 reset";

    // behavioural reference state
    bit          m_v = 0;
    bit          m_err = 0;
    logic [35:0] m_addr = '0;
    logic [2:0]  m_pool = '0;
    logic [35:0] sent_q[$];
    logic [35:0] got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bf_release_unit u_bf_release_unit (.*);

    // Reference model: advances on every rising edge from the bench inputs.
    always @(posedge clk) begin
        bit          acc, rel;
        longint      blk;
        if (!rst_n) begin
            m_v <= 0; m_err <= 0;
        end else begin
            acc = in_valid && (!m_v || rel_ready);
            if (m_v && rel_ready) begin
                got_q.push_back(m_addr);
                m_v <= 0;
            end
            m_err <= 0;
            if (acc) begin
                rel = (xfer_type == 2'd0) && (ptr_idx < src_count) &&
                      (hdr_ovr ? hdr_rel : (hdr_rel != ptr_inv));
                blk = longint'(ptr_addr) / 128;
                if (rel && blk < longint'(ptr_back)) begin
                    m_err <= 1;
                    m_v   <= 0;
                end else if (rel) begin
                    m_v    <= 1;
                    m_addr <= 36'((blk - longint'(ptr_back)) * 128);
                    m_pool <= ptr_pool;
                    sent_q.push_back(36'((blk - longint'(ptr_back)) * 128));
                end else begin
                    m_v <= 0;
                end
            end
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 in_ready", in_ready, !m_v || rel_ready);
            check("R9 rel_valid", rel_valid, m_v);
            check("R7 err_underflow", err_underflow, m_err);
            if (m_v && rel_valid) begin
                check("R4 rel_addr", rel_addr, m_addr);
                check("R5 rel_pool", rel_pool, m_pool);
            end
        end
    end

    // Back-pressure generator.
    initial begin
        forever begin
            @(posedge clk); #1;
            rel_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    task automatic send(input logic [1:0] t, input bit ov, input bit rl,
                        input int idx, input int cnt, input bit inv,
                        input int back, input int pool, input logic [35:0] a);
        bit took;
        xfer_type = t; hdr_ovr = ov; hdr_rel = rl;
        ptr_idx = 4'(idx); src_count = 4'(cnt); ptr_inv = inv;
        ptr_back = 4'(back); ptr_pool = 3'(pool); ptr_addr = a;
        in_valid = 1'b1;
        do begin
            @(negedge clk); took = in_ready;
            @(posedge clk); #1;
        end while (!took);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values
        check("R11 rel_valid", rel_valid, 0);
        check("R11 err_underflow", err_underflow, 0);
        check("R11 in_ready", in_ready, 1);
        @(posedge clk); #1;

        phase = "R1 non-outbound types";
        for (int t = 1; t < 4; t++)
            for (int k = 0; k < 4; k++)
                send(2'(t), k[0], 1'b1, 0, 4, k[1], 15, 5, 36'h000000100);

        phase = "R2 header override";
        for (int k = 0; k < 4; k++)
            send(2'd0, 1'b1, k[0], 1, 3, k[1], 2, k, 36'h123456789);

        phase = "R3 per-pointer invert";
        for (int k = 0; k < 4; k++)
            send(2'd0, 1'b0, k[0], 2, 3, k[1], 1, 7 - k, 36'h0ABCDEF12);

        phase = "R6 area boundary";
        send(2'd0, 1'b1, 1'b1, 3, 3, 1'b0, 0, 1, 36'h000004000);
        send(2'd0, 1'b1, 1'b1, 9, 3, 1'b0, 0, 1, 36'h000004000);
        send(2'd0, 1'b1, 1'b1, 0, 0, 1'b0, 0, 1, 36'h000004000);
        send(2'd0, 1'b1, 1'b1, 14, 15, 1'b0, 0, 2, 36'h000004000);

        phase = "R4 R5 address and pool";
        for (int k = 0; k < 16; k++)
            send(2'd0, 1'b1, 1'b1, 0, 1, 1'b0, k, k % 8,
                 36'({$urandom(), $urandom()}) | 36'h800);

        phase = "R7 underflow edge";
        send(2'd0, 1'b1, 1'b1, 0, 1, 1'b0, 6, 3, 36'h000000300); // exactly zero
        send(2'd0, 1'b1, 1'b1, 0, 1, 1'b0, 6, 3, 36'h0000002FF); // one block short
        send(2'd0, 1'b0, 1'b0, 0, 1, 1'b1, 1, 4, 36'h000000000);
        idle(2);

        phase = "R8 unused back and pool";
        send(2'd0, 1'b1, 1'b0, 0, 1, 1'b0, 15, 7, 36'h000000000);
        send(2'd0, 1'b0, 1'b1, 0, 1, 1'b1, 15, 6, 36'h000000010);
        idle(2);

        phase = "R9 R10 back-pressure";
        bp_on = 1'b1;
        for (int k = 0; k < 400; k++) begin
            send(2'($urandom_range(0, 4) == 0 ? $urandom_range(1, 3) : 0),
                 1'($urandom), 1'($urandom), $urandom_range(0, 15),
                 $urandom_range(0, 15), 1'($urandom), $urandom_range(0, 15),
                 $urandom_range(0, 7), 36'({$urandom(), $urandom()}) & 36'h00000FFFF);
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        bp_on = 1'b0;
        idle(6);
        // R10: order of completed requests matches acceptance order
        check("R10 count", got_q.size(), sent_q.size());
        foreach (got_q[i])
            if (i < sent_q.size()) check("R10 order", got_q[i], sent_q[i]);
        finish_run();
    end
endmodule